// File: doc/BRIEF.md
# Transceiver Speed Change Sequencer

This block steps a transceiver and the devices hanging off it through a change of line speed. It watches a one-bit requested speed and keeps three outputs: the speed the transceiver is currently programmed to, a flag saying the interface has left reset, and a flag saying the attached devices are ready for traffic.

Whenever the block is idle and either the requested speed differs from the programmed speed or the interface has not yet left reset, it launches a sequence on its own. The sequence follows a fixed, cycle-counted timeline. Both flags drop. The new speed is programmed. The interface is released from reset. After a settling wait that is short for high speed and long for full speed, the devices are declared ready. A request that changes while a sequence is running is only acted on once the running sequence has finished.

Top module: `xcvr_speed_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the programmed speed is full speed (0) and both the out-of-reset and devices-ready flags are 0.
- R2: Speed is one bit, 0 for full speed and 1 for high speed. In an idle cycle, a sequence launches if the requested speed differs from the programmed speed or if out-of-reset is 0. That idle cycle is called cycle 0.
- R3: A one-cycle gap separates the launch decision from the first step. The first step takes effect from cycle 2, where out-of-reset and devices-ready are both 0.
- R4: After two further idle cycles, the programmed speed takes the requested speed sampled in cycle 4. The new value is visible from cycle 5 and unchanged before it.
- R5: After two more idle cycles, out-of-reset becomes 1 from cycle 8.
- R6: If the speed just programmed is high speed, devices-ready becomes 1 from cycle 11. For full speed it becomes 1 from cycle 15. Before that it stays 0.
- R7: The cycle in which devices-ready first reads 1 is an idle cycle. If the request then matches the programmed speed, all outputs hold steady with no new sequence.
- R8: A change of the request after cycle 4 of a running sequence does not alter the programmed speed during that sequence. If the change leaves a mismatch, a new sequence launches in the idle cycle where devices-ready first reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_speed_i | input | 1 | Requested speed: 0 full, 1 high |
| cur_speed_o | output | 1 | Currently programmed transceiver speed |
| out_of_reset_o | output | 1 | Interface released from reset |
| dev_ready_o | output | 1 | Attached devices ready |

## Verification
The hardest situation to reach from the ports is a request that moves while a sequence is in flight. The cycle in which it moves decides whether it is absorbed by the current speed load or has to be carried over into a back-to-back relaunch. The bench sweeps the moment of change across every cycle of the timeline, for both directions of change, and predicts from the requirement timeline which speed gets loaded and whether a second sequence must follow. Steady idle periods with a matching request are checked for the absence of any relaunch.

// File: rtl/xss_pkg.sv
package xss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_HOLD_A,
    ST_LOAD,
    ST_HOLD_B,
    ST_RELEASE,
    ST_SETTLE,
    ST_READY
  } xss_state_e;

  localparam logic SPD_FULL = 1'b0;
  localparam logic SPD_HIGH = 1'b1;

  // Settling wait after release, chosen by the freshly programmed speed.
  function automatic int unsigned settle_len(input logic spd,
                                             input int unsigned hs_cyc,
                                             input int unsigned fs_cyc);
    return (spd == SPD_HIGH) ? hs_cyc : fs_cyc;
  endfunction

  // A new sequence is wanted when the speed mismatches or reset is still held.
  function automatic logic need_seq(input logic req, input logic cur, input logic oor);
    return (req != cur) || !oor;
  endfunction

endpackage

// File: rtl/xss_hold_timer.sv
module xss_hold_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  // Loading N makes the following hold state last exactly N cycles.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/xss_seq_ctrl.sv
module xss_seq_ctrl
  import xss_pkg::*;
#(
  parameter int unsigned CW            = 3,
  parameter int unsigned HOLD_A_CYC    = 2,
  parameter int unsigned HOLD_B_CYC    = 2,
  parameter int unsigned HS_SETTLE_CYC = 2,
  parameter int unsigned FS_SETTLE_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          expired_i,
  input  logic          cur_speed_i,
  output logic          idle_o,
  output logic          ev_clear_o,
  output logic          ev_load_o,
  output logic          ev_release_o,
  output logic          ev_ready_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_len_o
);

  xss_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    unique case (state_q)
      ST_IDLE:    if (launch_i) state_d = ST_CLEAR;
      ST_CLEAR: begin
        state_d    = ST_HOLD_A;
        tmr_load_o = 1'b1;
        tmr_len_o  = CW'(HOLD_A_CYC);
      end
      ST_HOLD_A:  if (expired_i) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d    = ST_HOLD_B;
        tmr_load_o = 1'b1;
        tmr_len_o  = CW'(HOLD_B_CYC);
      end
      ST_HOLD_B:  if (expired_i) state_d = ST_RELEASE;
      ST_RELEASE: begin
        state_d    = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_len_o  = CW'(settle_len(cur_speed_i, HS_SETTLE_CYC, FS_SETTLE_CYC));
      end
      ST_SETTLE:  if (expired_i) state_d = ST_READY;
      ST_READY:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign idle_o       = (state_q == ST_IDLE);
  assign ev_clear_o   = (state_q == ST_CLEAR);
  assign ev_load_o    = (state_q == ST_LOAD);
  assign ev_release_o = (state_q == ST_RELEASE);
  assign ev_ready_o   = (state_q == ST_READY);

endmodule

// File: rtl/xss_flag_bank.sv
module xss_flag_bank
  import xss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_speed_i,
  input  logic ev_clear_i,
  input  logic ev_load_i,
  input  logic ev_release_i,
  input  logic ev_ready_i,
  output logic speed_o,
  output logic oor_o,
  output logic rdy_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_o <= SPD_FULL;
      oor_o   <= 1'b0;
      rdy_o   <= 1'b0;
    end else begin
      if (ev_clear_i) begin
        oor_o <= 1'b0;
        rdy_o <= 1'b0;
      end
      if (ev_load_i)    speed_o <= req_speed_i;
      if (ev_release_i) oor_o   <= 1'b1;
      if (ev_ready_i)   rdy_o   <= 1'b1;
    end
  end

endmodule

// File: rtl/xcvr_speed_seq.sv
module xcvr_speed_seq
  import xss_pkg::*;
#(
  parameter int unsigned HOLD_A_CYC    = 2,
  parameter int unsigned HOLD_B_CYC    = 2,
  parameter int unsigned HS_SETTLE_CYC = 2,
  parameter int unsigned FS_SETTLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_speed_i,
  output logic cur_speed_o,
  output logic out_of_reset_o,
  output logic dev_ready_o
);

  localparam int unsigned MAX_HOLD_AB = (HOLD_A_CYC > HOLD_B_CYC) ? HOLD_A_CYC : HOLD_B_CYC;
  localparam int unsigned MAX_SETTLE  = (HS_SETTLE_CYC > FS_SETTLE_CYC) ? HS_SETTLE_CYC : FS_SETTLE_CYC;
  localparam int unsigned MAX_HOLD    = (MAX_HOLD_AB > MAX_SETTLE) ? MAX_HOLD_AB : MAX_SETTLE;
  localparam int unsigned CW          = (MAX_HOLD < 2) ? 1 : $clog2(MAX_HOLD + 1);

  // Named internal events, visible to the bound checker.
  logic          seq_idle;
  logic          seq_launch;
  logic          ev_clear;
  logic          ev_load;
  logic          ev_release;
  logic          ev_ready;
  logic          tmr_load;
  logic [CW-1:0] tmr_len;
  logic          tmr_expired;

  assign seq_launch = seq_idle && need_seq(req_speed_i, cur_speed_o, out_of_reset_o);

  xss_seq_ctrl #(
    .CW           (CW),
    .HOLD_A_CYC   (HOLD_A_CYC),
    .HOLD_B_CYC   (HOLD_B_CYC),
    .HS_SETTLE_CYC(HS_SETTLE_CYC),
    .FS_SETTLE_CYC(FS_SETTLE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (seq_launch),
    .expired_i   (tmr_expired),
    .cur_speed_i (cur_speed_o),
    .idle_o      (seq_idle),
    .ev_clear_o  (ev_clear),
    .ev_load_o   (ev_load),
    .ev_release_o(ev_release),
    .ev_ready_o  (ev_ready),
    .tmr_load_o  (tmr_load),
    .tmr_len_o   (tmr_len)
  );

  xss_hold_timer #(
    .CW(CW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expired_o(tmr_expired)
  );

  xss_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_speed_i (req_speed_i),
    .ev_clear_i  (ev_clear),
    .ev_load_i   (ev_load),
    .ev_release_i(ev_release),
    .ev_ready_i  (ev_ready),
    .speed_o     (cur_speed_o),
    .oor_o       (out_of_reset_o),
    .rdy_o       (dev_ready_o)
  );

endmodule

// File: rtl/xss_checker.sv
module xss_checker
  import xss_pkg::*;
#(
  parameter int unsigned HS_SETTLE_CYC = 2,
  parameter int unsigned FS_SETTLE_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic req_speed,
  input logic cur_speed,
  input logic oor,
  input logic rdy,
  input logic seq_idle,
  input logic ev_clear,
  input logic ev_load,
  input logic ev_release,
  input logic ev_ready
);

  // Cycles spent released but not yet ready; reset whenever reset is held.
  logic [15:0] rel_cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !oor) rel_cnt_q <= '0;
    else if (!rdy)      rel_cnt_q <= rel_cnt_q + 16'd1;
  end

  AST_LAUNCH_WHEN_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && ((req_speed != cur_speed) || !oor)) |=> !seq_idle) else $error("launch"); // R2

  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (!oor && !rdy)) else $error("clear"); // R3

  AST_SPEED_LOADS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (cur_speed == $past(req_speed))) else $error("load"); // R4

  AST_RELEASE_SETS_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> oor) else $error("release"); // R5

  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (rel_cnt_q == 16'(settle_len(cur_speed, HS_SETTLE_CYC, FS_SETTLE_CYC) + 1)))
    else $error("settle"); // R6

  AST_READY_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> (rdy && seq_idle)) else $error("ready"); // R7

  AST_RDY_NEEDS_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> oor) else $error("order"); // R7

  AST_QUIET_WHEN_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && (req_speed == cur_speed) && oor) |=> (seq_idle && $stable(cur_speed) && $stable(oor)))
    else $error("quiet"); // R7

  AST_SPEED_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !ev_load) |=> $stable(cur_speed)) else $error("held"); // R8

endmodule

bind xcvr_speed_seq xss_checker #(
  .HS_SETTLE_CYC(HS_SETTLE_CYC),
  .FS_SETTLE_CYC(FS_SETTLE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_speed (req_speed_i),
  .cur_speed (cur_speed_o),
  .oor       (out_of_reset_o),
  .rdy       (dev_ready_o),
  .seq_idle  (seq_idle),
  .ev_clear  (ev_clear),
  .ev_load   (ev_load),
  .ev_release(ev_release),
  .ev_ready  (ev_ready)
);

// File: tb/xcvr_speed_seq_tb_top.sv
module xcvr_speed_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic spd, oor, rdy;
  int   total = 0;
  int   bad = 0;
  bit   wd_fired = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xcvr_speed_seq dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_speed_i   (req),
    .cur_speed_o   (spd),
    .out_of_reset_o(oor),
    .dev_ready_o   (rdy)
  );

  // Compare {speed, out_of_reset, ready} against the expectation.
  task automatic chk(input string tag, input logic [2:0] exp);
    total++;
    if ({spd, oor, rdy} !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act={spd,oor,rdy}=%b exp=%b", tag, $time, {spd, oor, rdy}, exp);
    end
  endtask

  // Entered at the negedge of launch cycle 0. Walks cycles 1 .. 9+W,
  // optionally moving the request at cycle chg_c. Returns the loaded speed.
  task automatic run_seq(input logic p_spd, input logic p_oor, input logic p_rdy,
                         input int chg_c, input logic chg_v, output logic loaded);
    int w;
    logic [2:0] e;
    loaded = (chg_c >= 1 && chg_c <= 4) ? chg_v : req;
    w = loaded ? 2 : 6;
    for (int c = 1; c <= 9 + w; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1) begin
        e = {p_spd, p_oor, p_rdy};
        chk("R3 gap", e);
      end else begin
        e[2] = (c >= 5) ? loaded : p_spd;
        e[1] = (c >= 8);
        e[0] = (c >= 9 + w);
        if (c <= 4)          chk("R4 speed not yet loaded", e);
        else if (c <= 7)     chk("R4/R3 speed loaded, flags low", e);
        else if (c < 9 + w)  chk("R5/R6 released, settling", e);
        else                 chk("R6/R7 ready", e);
      end
      if (c == chg_c) req = chg_v;
    end
  endtask

  // Expect no relaunch while the request matches.
  task automatic quiet(input int n, input string tag);
    logic [2:0] e;
    e = {spd, 1'b1, 1'b1};
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(tag, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    wd_fired = 1'b1;
  end

  initial begin : stim
    logic ld, ld2;
    @(negedge clk);
    chk("R1 in reset", 3'b000);
    @(negedge clk);
    chk("R1 in reset", 3'b000);
    rst_n = 1'b1;
    chk("R1 after reset", 3'b000);
    // R2: out-of-reset low alone launches the first sequence (request = full).
    run_seq(1'b0, 1'b0, 1'b0, 0, 1'b0, ld);
    quiet(5, "R7 settled full speed");

    // R2/R6: plain speed changes in both directions.
    for (int k = 0; k < 4; k++) begin
      req = ~spd;
      run_seq(spd, 1'b1, 1'b1, 0, 1'b0, ld);
      quiet(3, "R7 settled after change");
    end

    // R8: sweep the moment of a request change over the whole timeline.
    for (int dir = 0; dir < 2; dir++) begin
      for (int cc = 1; cc <= 15; cc++) begin
        logic tgt;
        tgt = dir[0];
        if (spd == tgt) begin
          req = ~spd;
          run_seq(spd, 1'b1, 1'b1, 0, 1'b0, ld);
        end
        // Now spd == tgt; request the other speed, then flip it back at cc.
        req = ~spd;
        run_seq(spd, 1'b1, 1'b1, (cc <= (req ? 11 : 15)) ? cc : 0, spd, ld);
        if (req != ld) begin
          // R8: mismatch left over launches straight from the ready cycle.
          run_seq(ld, 1'b1, 1'b1, 0, 1'b0, ld2);
          if (ld2 !== req) begin
            bad++; total++;
            $display("FAIL R8 relaunch loaded act=%b exp=%b", ld2, req);
          end else total++;
        end
        quiet(2, "R8 settled after sweep");
      end
    end

    // R7: long idle with a matching request stays still.
    quiet(20, "R7 long idle");
    finish_run();
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (wd_fired) begin
      wd_fired = 1'b0;
      total++;
      bad++;
      $display("FAIL watchdog act=expired exp=completed");
      finish_run();
    end
  end

endmodule